// File: doc/BRIEF.md
# Twin Down-Counter Timer Bank

This block places two identical programmable down-counting timers behind one 4 KB register window. A single synchronous request port (request, write strobe, byte offset, write data) reaches both. The lowest 32 bytes belong to the first timer and the next 32 bytes to the second. The second timer's offsets are rebased, so both timers present the same register layout. Near the top of the window sits a fixed eight-byte identification table and a pair of test-control words that read as zero. Any other access reports a one-cycle error pulse.

Each timer counts down on its own tick-enable input, after an optional divide-by-16 or divide-by-256 prescaler. It runs in one of three modes: free-running, periodic reload or one-shot. It raises a sticky flag when the count reaches zero by decrement. A per-timer enable gates that flag onto an interrupt line. The two interrupt lines leave the block separately, and also merged into one combined line. A typical system drives both tick inputs from slower rate strobes, for example 1 MHz each, and wires either the per-timer lines or the merged line to its interrupt controller.

Top module: `tt_dual_timer`

## Requirements
- R1: After reset each timer's control word reads 0x20 (interrupt enable set, everything else clear). Count, reload value and flag read 0. All interrupt outputs, `rdata_o` and `err_o` are low.
- R2: Word-aligned offsets 0x00–0x1F address timer 0 and 0x20–0x3F address timer 1 with 0x20 removed. An access to one timer never changes the other.
- R3: Inside a timer window the words are: 0x00 reload value (read/write), 0x04 current count (read only, writes ignored), 0x08 control (low 8 bits), 0x0C flag clear (write only), 0x10 raw flag in bit 0, 0x14 masked flag in bit 0, 0x18 reload value written without touching the count. Read data and `err_o` appear on the cycle after the request.
- R4: A write to 0x00 sets both the reload value and the count. A write to 0x18 sets only the reload value.
- R5: While control bit 7 is set, each scaled tick decrements a nonzero count. A decrement that reaches zero sets the raw flag.
- R6: A scaled tick at count zero behaves by mode. With control bit 0 set (one-shot) the count stays at zero. Otherwise, with bit 6 set (periodic) the count reloads the reload value. With both clear (free-running) it reloads 0xFFFF, or 0xFFFFFFFF when bit 1 is set.
- R7: Control bits 3:2 select the prescale: 00 and 11 count every tick, 01 every 16th tick and 10 every 256th tick, counted from the moment bit 7 is set.
- R8: Each timer's interrupt output equals its raw flag AND control bit 5, and the masked word reads the same. A write to 0x0C clears the raw flag.
- R9: `irq_any_o` is high exactly when either per-timer interrupt output is high.
- R10: Reads of 0xFE0–0xFFC return, by (offset−0xFE0)>>2, the bytes 0x04, 0x18, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in bits 7:0, with upper bits zero and no error.
- R11: Reads of 0xF00 and 0xF04 return zero with no error.
- R12: Any other read, including 0x0C/0x1C inside a timer window and any offset with bits 1:0 nonzero, returns zero and pulses `err_o` for one cycle. The same applies to a write outside 0x00–0x3F or unaligned, and such a write changes no timer state.
- R13: With control bit 1 clear, loading a value puts only its low 16 bits into the count, while the reload word reads back all 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte offset in the window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read |
| err_o | output | 1 | One-cycle pulse after an unmapped access |
| tick_i | input | 2 | Per-timer tick enable, bit n for timer n |
| irq_o | output | 2 | Per-timer interrupt, bit n for timer n |
| irq_any_o | output | 1 | OR of both timer interrupts |

## Verification
The assertions assume that reset is held for at least one clock, and that `req_i` is low during reset so that no error can trace back to a request made inside reset. They also take it that a load write and a scaled tick arriving together are resolved in favour of the load, and they exclude that case from the zero-crossing and one-shot checks. The stimulus drives each request for exactly one cycle, holds ticks low around every register access it checks, and draws random addresses only from aligned offsets in the unmapped span between 0x40 and 0xEFF.

// File: rtl/tt_pkg.sv
package tt_pkg;

    localparam int DATA_W   = 32;
    localparam int HALF_W   = 16;
    localparam int ADDR_W   = 12;
    localparam int CTRL_W   = 8;
    localparam int IDX_W    = 3;
    localparam int NUM_TMR  = 2;
    localparam int PS_W     = 8;

    // Control byte: field positions are visible to software.
    typedef struct packed {
        logic       enable;    // bit 7
        logic       periodic;  // bit 6
        logic       irq_en;    // bit 5
        logic       spare;     // bit 4
        logic [1:0] scale;     // bits 3:2
        logic       wide;      // bit 1
        logic       oneshot;   // bit 0
    } tmr_ctrl_t;

    localparam tmr_ctrl_t CTRL_RESET = '{enable: 1'b0, periodic: 1'b0, irq_en: 1'b1,
                                         spare: 1'b0, scale: 2'b00, wide: 1'b0,
                                         oneshot: 1'b0};

    typedef enum logic [1:0] {
        SC_DIV1   = 2'b00,
        SC_DIV16  = 2'b01,
        SC_DIV256 = 2'b10,
        SC_RSVD   = 2'b11
    } scale_e;

    // Word index inside one timer window.
    typedef enum logic [IDX_W-1:0] {
        IX_RELOAD = 3'd0,
        IX_COUNT  = 3'd1,
        IX_CTRL   = 3'd2,
        IX_ACK    = 3'd3,
        IX_RAW    = 3'd4,
        IX_MASKED = 3'd5,
        IX_SHADOW = 3'd6,
        IX_NONE   = 3'd7
    } reg_idx_e;

    typedef enum logic [1:0] {
        RG_TIMER = 2'd0,
        RG_TEST  = 2'd1,
        RG_IDENT = 2'd2,
        RG_NONE  = 2'd3
    } region_e;

    typedef struct packed {
        region_e          region;
        logic             tmr_sel;
        logic [IDX_W-1:0] idx;
    } decode_t;

    function automatic logic [DATA_W-1:0] fit_count(input logic [DATA_W-1:0] v,
                                                    input logic wide);
        return wide ? v : {{(DATA_W-HALF_W){1'b0}}, v[HALF_W-1:0]};
    endfunction

    function automatic logic [7:0] ident_byte(input logic [IDX_W-1:0] i);
        case (i)
            3'd0:    return 8'h04;
            3'd1:    return 8'h18;
            3'd2:    return 8'h14;
            3'd3:    return 8'h00;
            3'd4:    return 8'h0D;
            3'd5:    return 8'hF0;
            3'd6:    return 8'h05;
            default: return 8'hB1;
        endcase
    endfunction

endpackage

// File: rtl/tt_prescale.sv
module tt_prescale
    import tt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run_i,
    input  logic       tick_i,
    input  logic [1:0] scale_i,
    output logic       fire_o
);
    logic [PS_W-1:0] cnt_q;
    logic            wrap;

    always_comb begin
        case (scale_e'(scale_i))
            SC_DIV16:  wrap = (cnt_q[3:0] == 4'hF);
            SC_DIV256: wrap = (cnt_q == {PS_W{1'b1}});
            default:   wrap = 1'b1;
        endcase
    end

    assign fire_o = run_i & tick_i & wrap;

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/tt_addr_map.sv
module tt_addr_map
    import tt_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    output decode_t           dec_o
);
    localparam int TMR_SPAN_B = 6;   // two 32-byte windows

    always_comb begin
        dec_o.region  = RG_NONE;
        dec_o.tmr_sel = addr_i[5];
        dec_o.idx     = addr_i[4:2];
        if (addr_i[1:0] != 2'b00) begin
            dec_o.region = RG_NONE;
        end else if (addr_i[ADDR_W-1:TMR_SPAN_B] == '0) begin
            dec_o.region = RG_TIMER;
        end else if (addr_i[ADDR_W-1:5] == {(ADDR_W-5){1'b1}}) begin
            dec_o.region = RG_IDENT;
        end else if (addr_i[ADDR_W-1:3] == 9'h1E0) begin
            dec_o.region = RG_TEST;
        end
    end

endmodule

// File: rtl/tt_timer_core.sv
module tt_timer_core
    import tt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              wr_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_hit_o,
    output logic              irq_o
);
    tmr_ctrl_t         ctrl_q;
    logic [DATA_W-1:0] reload_q;
    logic [DATA_W-1:0] cnt_q;
    logic [DATA_W-1:0] cnt_step;
    logic              raw_q;
    logic              fire;
    logic              wr_load;

    tt_prescale u_pre (
        .clk     (clk),
        .rst     (rst),
        .run_i   (ctrl_q.enable),
        .tick_i  (tick_i),
        .scale_i (ctrl_q.scale),
        .fire_o  (fire)
    );

    assign wr_load = wr_i && (idx_i == IX_RELOAD);

    always_comb begin
        if (cnt_q != '0) begin
            cnt_step = cnt_q - 1'b1;
        end else if (ctrl_q.oneshot) begin
            cnt_step = '0;
        end else if (ctrl_q.periodic) begin
            cnt_step = fit_count(reload_q, ctrl_q.wide);
        end else begin
            cnt_step = fit_count({DATA_W{1'b1}}, ctrl_q.wide);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= CTRL_RESET;
            reload_q <= '0;
            cnt_q    <= '0;
            raw_q    <= 1'b0;
        end else begin
            if (wr_i && idx_i == IX_CTRL) begin
                ctrl_q <= tmr_ctrl_t'(wdata_i[CTRL_W-1:0]);
            end
            if (wr_i && (idx_i == IX_RELOAD || idx_i == IX_SHADOW)) begin
                reload_q <= wdata_i;
            end
            if (wr_load) begin
                cnt_q <= fit_count(wdata_i, ctrl_q.wide);
            end else if (fire) begin
                cnt_q <= cnt_step;
            end
            if (fire && !wr_load && cnt_q == {{(DATA_W-1){1'b0}}, 1'b1}) begin
                raw_q <= 1'b1;
            end else if (wr_i && idx_i == IX_ACK) begin
                raw_q <= 1'b0;
            end
        end
    end

    assign irq_o = raw_q & ctrl_q.irq_en;

    always_comb begin
        rd_hit_o  = 1'b1;
        rd_data_o = '0;
        case (reg_idx_e'(idx_i))
            IX_RELOAD, IX_SHADOW: rd_data_o = reload_q;
            IX_COUNT:             rd_data_o = cnt_q;
            IX_CTRL:              rd_data_o = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
            IX_RAW:               rd_data_o = {{(DATA_W-1){1'b0}}, raw_q};
            IX_MASKED:            rd_data_o = {{(DATA_W-1){1'b0}}, irq_o};
            default:              rd_hit_o  = 1'b0;
        endcase
    end

    // R4: a load write puts the (width-fitted) value into the count
    a_r4_load_sets_count: assert property (@(posedge clk) disable iff (rst)
        wr_load |=> cnt_q == fit_count($past(wdata_i), $past(ctrl_q.wide)));

    // R5: a decrement reaching zero leaves the raw flag set
    a_r5_zero_raises_flag: assert property (@(posedge clk) disable iff (rst)
        (fire && !wr_load && cnt_q == {{(DATA_W-1){1'b0}}, 1'b1}) |=> raw_q);

    // R6: a one-shot timer parked at zero stays there
    a_r6_oneshot_parks: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.oneshot && cnt_q == '0 && !wr_load) |=> cnt_q == '0);

    // R8: the interrupt line never rises without the enable bit
    a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> ctrl_q.irq_en);

endmodule

// File: rtl/tt_dual_timer.sv
module tt_dual_timer
    import tt_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                req_i,
    input  logic                we_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [DATA_W-1:0]   wdata_i,
    output logic [DATA_W-1:0]   rdata_o,
    output logic                err_o,
    input  logic [NUM_TMR-1:0]  tick_i,
    output logic [NUM_TMR-1:0]  irq_o,
    output logic                irq_any_o
);
    decode_t           dec;
    logic [DATA_W-1:0] core_rd  [NUM_TMR];
    logic [NUM_TMR-1:0] core_hit;
    logic [DATA_W-1:0] rd_next;
    logic              bad_next;

    tt_addr_map u_map (
        .addr_i (addr_i),
        .dec_o  (dec)
    );

    for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
        logic sel;
        assign sel = req_i && we_i && dec.region == RG_TIMER && dec.tmr_sel == g[0];
        tt_timer_core u_core (
            .clk       (clk),
            .rst       (rst),
            .tick_i    (tick_i[g]),
            .wr_i      (sel),
            .idx_i     (dec.idx),
            .wdata_i   (wdata_i),
            .rd_data_o (core_rd[g]),
            .rd_hit_o  (core_hit[g]),
            .irq_o     (irq_o[g])
        );
    end

    assign irq_any_o = |irq_o;

    always_comb begin
        rd_next  = '0;
        bad_next = 1'b0;
        case (dec.region)
            RG_TIMER: begin
                rd_next  = core_rd[dec.tmr_sel];
                bad_next = !we_i && !core_hit[dec.tmr_sel];
            end
            RG_IDENT: begin
                rd_next  = {{(DATA_W-8){1'b0}}, ident_byte(dec.idx)};
                bad_next = we_i;
            end
            RG_TEST:  bad_next = we_i;
            default:  bad_next = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_o <= '0;
            err_o   <= 1'b0;
        end else begin
            err_o <= req_i && bad_next;
            if (req_i && !we_i) begin
                rdata_o <= rd_next;
            end
        end
    end

    // R12: an error pulse always traces back to a request
    a_r12_err_after_req: assert property (@(posedge clk) disable iff (rst)
        err_o |-> $past(req_i));

    // R10: identification reads leave the upper bits clear
    a_r10_ident_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (req_i && !we_i && dec.region == RG_IDENT) |=> rdata_o[DATA_W-1:8] == '0);

    // R11: test-control reads return zero without error
    a_r11_test_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (req_i && !we_i && dec.region == RG_TEST) |=> (rdata_o == '0 && !err_o));

endmodule

// File: tb/tt_dual_timer_bench.sv
module tt_dual_timer_bench;
    import tt_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_i = 1'b0;
    logic        we_i = 1'b0;
    logic [11:0] addr_i = '0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic        err_o;
    logic [1:0]  tick_i = '0;
    logic [1:0]  irq_o;
    logic        irq_any_o;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    tt_dual_timer u_tt_dual_timer (
        .clk(clk), .rst(rst), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .rdata_o(rdata_o), .err_o(err_o), .tick_i(tick_i),
        .irq_o(irq_o), .irq_any_o(irq_any_o)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            bad   = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=fewer", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, output logic e);
        @(negedge clk);
        req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
        @(negedge clk);
        req_i = 1'b0; we_i = 1'b0;
        e = err_o;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d, output logic e);
        @(negedge clk);
        req_i = 1'b1; we_i = 1'b0; addr_i = a;
        @(negedge clk);
        req_i = 1'b0;
        d = rdata_o; e = err_o;
    endtask

    task automatic ticks(input logic [1:0] m, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_i = m;
        end
        @(negedge clk);
        tick_i = '0;
    endtask

    // Expected periodic count and flag after n undivided ticks.
    function automatic logic [32:0] model_periodic(input logic [31:0] c0,
                                                   input logic [31:0] lim, input int n);
        logic [31:0] c = c0;
        logic f = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (c == 0) c = lim;
            else begin
                c = c - 1;
                if (c == 0) f = 1'b1;
            end
        end
        return {f, c};
    endfunction

    localparam logic [7:0] ID_TAB [8] = '{8'h04, 8'h18, 8'h14, 8'h00,
                                          8'h0D, 8'hF0, 8'h05, 8'hB1};

    logic [31:0] d;
    logic        e;

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 rdata", rdata_o, 0);
        chk("R1 err", {31'b0, err_o}, 0);
        chk("R1 irq", {29'b0, irq_any_o, irq_o}, 0);
        rd(12'h008, d, e); chk("R1 ctrl t0", d, 32'h20);
        rd(12'h028, d, e); chk("R1 ctrl t1", d, 32'h20);
        rd(12'h004, d, e); chk("R1 count t0", d, 0);
        rd(12'h030, d, e); chk("R1 raw t1", d, 0);

        // R10 identification table
        for (int i = 0; i < 8; i++) begin
            rd(12'hFE0 + 12'(i*4), d, e);
            chk("R10 ident", d, {24'b0, ID_TAB[i]});
            chk("R10 ident err", {31'b0, e}, 0);
        end

        // R11 test words
        rd(12'hF00, d, e); chk("R11 f00", {d[30:0], e}, 0);
        rd(12'hF04, d, e); chk("R11 f04", {d[30:0], e}, 0);

        // R12 fixed unmapped reads
        rd(12'h040, d, e); chk("R12 040", {d[30:0], e}, 1);
        rd(12'hF08, d, e); chk("R12 f08", {d[30:0], e}, 1);
        rd(12'h01C, d, e); chk("R12 01c", {d[30:0], e}, 1);
        rd(12'h02C, d, e); chk("R12 ack read", {d[30:0], e}, 1);
        rd(12'h009, d, e); chk("R12 unaligned", {d[30:0], e}, 1);
        // R12 random unmapped reads
        for (int i = 0; i < 20; i++) begin
            logic [11:0] a;
            a = (12'h040 + 12'($urandom % 12'hEC0)) & 12'hFFC;
            rd(a, d, e); chk("R12 random unmapped", {d[30:0], e}, 1);
        end

        // R2 R4 R13 random loads to both timers, 16-bit mode
        for (int i = 0; i < 8; i++) begin
            logic [31:0] va, vb;
            va = $urandom; vb = $urandom;
            wr(12'h000, va, e); chk("R12 mapped write no err", {31'b0, e}, 0);
            wr(12'h020, vb, e);
            rd(12'h000, d, e); chk("R2 reload t0", d, va);
            rd(12'h020, d, e); chk("R2 reload t1", d, vb);
            rd(12'h004, d, e); chk("R13 count t0 16b", d, {16'b0, va[15:0]});
            rd(12'h024, d, e); chk("R13 count t1 16b", d, {16'b0, vb[15:0]});
        end

        // R4 shadow write, count-write ignored, bad write ignored
        wr(12'h008, 32'h0000_0022, e);      // wide, disabled
        wr(12'h000, 32'h1234_5678, e);
        wr(12'h018, 32'h0000_0777, e);
        rd(12'h000, d, e); chk("R4 shadow sets reload", d, 32'h777);
        rd(12'h004, d, e); chk("R4 shadow keeps count", d, 32'h1234_5678);
        wr(12'h004, 32'hDEAD_BEEF, e);
        rd(12'h004, d, e); chk("R3 count write ignored", d, 32'h1234_5678);
        wr(12'h100, 32'h0000_0055, e); chk("R12 bad write err", {31'b0, e}, 1);
        wr(12'h001, 32'h0000_00FF, e); chk("R12 unaligned write err", {31'b0, e}, 1);
        rd(12'h004, d, e); chk("R12 bad write no effect", d, 32'h1234_5678);
        rd(12'h008, d, e); chk("R12 bad write ctrl kept", d, 32'h22);

        // R5 R6 R8 R9 periodic on timer 0
        wr(12'h000, 32'd5, e);
        wr(12'h008, 32'hE2, e);
        ticks(2'b01, 5);
        rd(12'h004, d, e); chk("R5 count at zero", d, 0);
        rd(12'h010, d, e); chk("R5 raw set", d, 1);
        chk("R8 irq t0", {30'b0, irq_o}, 2'b01);
        chk("R9 irq any", {31'b0, irq_any_o}, 1);
        rd(12'h014, d, e); chk("R8 masked", d, 1);
        ticks(2'b01, 1);
        rd(12'h004, d, e); chk("R6 periodic reload", d, 5);
        rd(12'h024, d, e); chk("R2 t1 untouched", d[31:16], 0);
        wr(12'h00C, 0, e);
        rd(12'h010, d, e); chk("R8 ack clears", d, 0);
        chk("R9 any low", {29'b0, irq_any_o, irq_o}, 0);
        wr(12'h008, 32'hC2, e);             // interrupt enable off
        ticks(2'b01, 5);
        rd(12'h010, d, e); chk("R8 raw without enable", d, 1);
        rd(12'h014, d, e); chk("R8 masked off", d, 0);
        chk("R8 irq off", {30'b0, irq_o}, 0);
        wr(12'h00C, 0, e);

        // R6 one-shot on timer 1
        wr(12'h028, 32'h22, e);
        wr(12'h020, 32'd3, e);
        wr(12'h028, 32'hA3, e);
        ticks(2'b10, 5);
        rd(12'h024, d, e); chk("R6 oneshot parked", d, 0);
        chk("R9 irq t1 only", {29'b0, irq_any_o, irq_o}, 3'b110);
        wr(12'h02C, 0, e);

        // R6 free-running 16 and 32 bit
        wr(12'h008, 32'h00, e);
        wr(12'h000, 32'd1, e);
        wr(12'h008, 32'h80, e);
        ticks(2'b01, 2);
        rd(12'h004, d, e); chk("R6 free 16b", d, 32'h0000_FFFF);
        wr(12'h008, 32'h02, e);
        wr(12'h000, 32'd1, e);
        wr(12'h008, 32'h82, e);
        ticks(2'b01, 2);
        rd(12'h004, d, e); chk("R6 free 32b", d, 32'hFFFF_FFFF);

        // R7 prescale
        wr(12'h008, 32'h02, e);
        wr(12'h000, 32'd100, e);
        wr(12'h008, 32'hC6, e);
        ticks(2'b01, 31);
        rd(12'h004, d, e); chk("R7 div16 31 ticks", d, 99);
        ticks(2'b01, 1);
        rd(12'h004, d, e); chk("R7 div16 32 ticks", d, 98);
        wr(12'h008, 32'h02, e);
        wr(12'h000, 32'd10, e);
        wr(12'h008, 32'hCA, e);
        ticks(2'b01, 255);
        rd(12'h004, d, e); chk("R7 div256 255 ticks", d, 10);
        ticks(2'b01, 1);
        rd(12'h004, d, e); chk("R7 div256 256 ticks", d, 9);
        wr(12'h008, 32'h02, e);
        wr(12'h000, 32'd10, e);
        wr(12'h008, 32'hCE, e);
        ticks(2'b01, 3);
        rd(12'h004, d, e); chk("R7 scale 11 every tick", d, 7);

        // R5 R6 random periodic runs on timer 1
        for (int i = 0; i < 10; i++) begin
            logic [31:0] lim;
            logic [32:0] ex;
            int n;
            lim = 32'($urandom_range(1, 20));
            n = $urandom_range(0, 60);
            wr(12'h028, 32'h42, e);
            wr(12'h02C, 0, e);
            wr(12'h020, lim, e);
            wr(12'h028, 32'hC2, e);
            ticks(2'b10, n);
            ex = model_periodic(lim, lim, n);
            rd(12'h024, d, e); chk("R6 random periodic count", d, ex[31:0]);
            rd(12'h030, d, e); chk("R5 random flag", d, {31'b0, ex[32]});
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule